// File: doc/BRIEF.md
# Address Latch with Plus/Minus One-or-Two Stepper

This block holds a 16-bit address captured from the internal register bus and presents it on the address output. The same held value is the operand of a stepping unit that adds or subtracts one or two, wrapping modulo 2^16. The stepped value is offered as a write-back word, so the surrounding datapath can update the program counter, the stack pointer or a register pair with it.

A typical sequence loads the program counter into the latch, drives it out as an address and writes the stepped value back. A step of two lets a not-taken jump or call skip its two address bytes in a single operation. Push and pop adjust the stack pointer by stepping down or up. A 16-bit register increment or decrement uses the same path.

The unit also reports the carry out of the top bit when stepping up, or the borrow when stepping down. The surrounding logic can use this as a flag input.

Top module: `addr_stepper`

## Requirements
- R1: While the synchronous active-high reset is asserted at a clock edge, the held address becomes 0x0000.
- R2: When the load strobe is high at a rising clock edge (and reset is low), the held address output equals the bus value from that edge, starting from the edge itself.
- R3: When neither the load strobe nor reset is high at a clock edge, the held address keeps its value.
- R4: With only the up select and only the step-of-1 select high, the result is the held address plus 1 modulo 65536, and the carry output is 1 exactly when the held address is 0xFFFF.
- R5: With only the up select and the step-of-2 select high, the result is the held address plus 2 modulo 65536, and the carry is 1 exactly when the held address is 0xFFFE or 0xFFFF.
- R6: With only the down select and only the step-of-1 select high, the result is the held address minus 1 modulo 65536, and the carry output (acting as borrow) is 1 exactly when the held address is 0x0000.
- R7: With only the down select and the step-of-2 select high, the result is the held address minus 2 modulo 65536, and the borrow is 1 exactly when the held address is 0x0000 or 0x0001.
- R8: When both direction selects are high, or both are low, the result equals the held address and the carry is 0, whatever the step selects are.
- R9: When neither step select is high, the result equals the held address and the carry is 0, whatever the direction selects are.
- R10: When both step selects are high, the step of 2 is used.
- R11: The result and carry depend combinationally on the held address and the selects, with no added register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Captures bus_val into the latch at the clock edge |
| bus_val | input | 16 | Register-bus value to capture |
| go_up | input | 1 | Direction select: step upward |
| go_down | input | 1 | Direction select: step downward |
| by_one | input | 1 | Step-size select: 1 |
| by_two | input | 1 | Step-size select: 2 (wins over by_one) |
| addr_out | output | 16 | Held address |
| step_val | output | 16 | Stepped write-back value |
| carry_out | output | 1 | Carry out of bit 15 when stepping up, borrow when stepping down |

## Verification
The held address changes one edge after the load strobe is seen, so it is compared against the bench model shortly after the following falling edge. The stepped value and carry follow the latch and the selects within the same cycle. Each cycle the bench therefore drives the selects at the falling edge, waits one time unit, and compares against a model that is updated only at rising edges. The wrap values at 0xFFFE, 0xFFFF, 0x0000 and 0x0001 are loaded directly in both directions and with both step sizes, and a long stretch of random stimulus covers the mixed and idle select patterns.

// File: rtl/addr_step_pkg.sv
package addr_step_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_dir_e;

  localparam int unsigned BIG_STEP   = 2;
  localparam int unsigned SMALL_STEP = 1;

endpackage

// File: rtl/addr_latch_reg.sv
module addr_latch_reg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_out <= '0;
    end else if (load_en) begin
      q_out <= d_in;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (q_out == '0)); // R1

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (q_out == $past(d_in))); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(q_out)); // R3

endmodule

// File: rtl/step_ctrl.sv
module step_ctrl
  import addr_step_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             go_up,
  input  logic             go_down,
  input  logic             by_one,
  input  logic             by_two,
  output logic [WIDTH-1:0] operand,
  output logic             carry_in,
  output logic             subtract
);

  step_dir_e        dir;
  logic [WIDTH-1:0] magnitude;

  always_comb begin
    if (go_up && !go_down)      dir = STEP_UP;
    else if (go_down && !go_up) dir = STEP_DOWN;
    else                        dir = STEP_HOLD;
  end

  always_comb begin
    if (by_two)      magnitude = WIDTH'(BIG_STEP);
    else if (by_one) magnitude = WIDTH'(SMALL_STEP);
    else             magnitude = '0;
  end

  always_comb begin
    unique case (dir)
      STEP_UP: begin
        operand  = magnitude;
        carry_in = 1'b0;
        subtract = 1'b0;
      end
      STEP_DOWN: begin
        operand  = ~magnitude;
        carry_in = 1'b1;
        subtract = 1'b1;
      end
      default: begin
        operand  = '0;
        carry_in = 1'b0;
        subtract = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             c_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             c_out
);

  logic [WIDTH:0] carry;

  assign carry[0] = c_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic p_bit;
    assign p_bit      = a_in[i] ^ b_in[i];
    assign sum_out[i] = p_bit ^ carry[i];
    assign carry[i+1] = (a_in[i] & b_in[i]) | (p_bit & carry[i]);
  end

  assign c_out = carry[WIDTH];

endmodule

// File: rtl/addr_stepper.sv
module addr_stepper #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] bus_val,
  input  logic              go_up,
  input  logic              go_down,
  input  logic              by_one,
  input  logic              by_two,
  output logic [ADDR_W-1:0] addr_out,
  output logic [ADDR_W-1:0] step_val,
  output logic              carry_out
);

  localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] held;
  logic [ADDR_W-1:0] operand;
  logic              cin;
  logic              sub_mode;
  logic              chain_cout;

  addr_latch_reg #(.WIDTH(ADDR_W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .d_in    (bus_val),
    .q_out   (held)
  );

  step_ctrl #(.WIDTH(ADDR_W)) u_ctrl (
    .go_up    (go_up),
    .go_down  (go_down),
    .by_one   (by_one),
    .by_two   (by_two),
    .operand  (operand),
    .carry_in (cin),
    .subtract (sub_mode)
  );

  ripple_chain #(.WIDTH(ADDR_W)) u_chain (
    .a_in    (held),
    .b_in    (operand),
    .c_in    (cin),
    .sum_out (step_val),
    .c_out   (chain_cout)
  );

  assign addr_out  = held;
  assign carry_out = sub_mode ? ~chain_cout : chain_cout;

  AST_UP_ONE: assert property (@(posedge clk) disable iff (rst)
    (go_up && !go_down && by_one && !by_two) |->
      (step_val == addr_out + ADDR_W'(1)) && (carry_out == (addr_out == ALL_ONES))); // R4

  AST_DOWN_ONE: assert property (@(posedge clk) disable iff (rst)
    (go_down && !go_up && by_one && !by_two) |->
      (step_val == addr_out - ADDR_W'(1)) && (carry_out == (addr_out == '0))); // R6

  AST_DIR_IDLE: assert property (@(posedge clk) disable iff (rst)
    (go_up == go_down) |-> (step_val == addr_out) && !carry_out); // R8

  AST_SIZE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!by_one && !by_two) |-> (step_val == addr_out) && !carry_out); // R9

  AST_TWO_WINS: assert property (@(posedge clk) disable iff (rst)
    (go_up && !go_down && by_one && by_two) |->
      (step_val == addr_out + ADDR_W'(2))); // R10

endmodule

// File: tb/addr_stepper_test.sv
module addr_stepper_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        load_en;
  logic [15:0] bus_val;
  logic        go_up, go_down, by_one, by_two;
  logic [15:0] addr_out, step_val;
  logic        carry_out;

  int checks = 0;
  int errors = 0;
  logic [15:0] model_addr = 16'h0;
  bit finished = 0;

  always #4 clk = ~clk;

  addr_stepper uut (
    .clk(clk), .rst(rst), .load_en(load_en), .bus_val(bus_val),
    .go_up(go_up), .go_down(go_down), .by_one(by_one), .by_two(by_two),
    .addr_out(addr_out), .step_val(step_val), .carry_out(carry_out)
  );

  // Behavioural reference: latch updated only at rising edges
  always @(posedge clk) begin
    if (rst) model_addr <= 16'h0;
    else if (load_en) model_addr <= bus_val;
  end

  function automatic string pick_tag();
    if (go_up == go_down) return "R8";
    if (!by_one && !by_two) return "R9";
    if (by_one && by_two) return "R10";
    if (go_up) return by_two ? "R5" : "R4";
    return by_two ? "R7" : "R6";
  endfunction

  task automatic compare(input string tag);
    int step;
    int raw;
    int exp_val;
    int exp_c;
    step = by_two ? 2 : (by_one ? 1 : 0);
    raw = int'(model_addr);
    if (go_up && !go_down) begin
      exp_val = (raw + step) % 65536;
      exp_c = (raw + step > 65535) ? 1 : 0;
    end else if (go_down && !go_up) begin
      exp_val = (raw - step + 65536) % 65536;
      exp_c = (raw - step < 0) ? 1 : 0;
    end else begin
      exp_val = raw;
      exp_c = 0;
    end
    checks++;
    if (addr_out !== model_addr) begin
      errors++;
      $display("FAIL %s addr_out actual %h expected %h", tag, addr_out, model_addr);
    end
    checks++;
    if (step_val !== 16'(exp_val) || carry_out !== 1'(exp_c)) begin
      errors++;
      $display("FAIL %s step_val/carry actual %h/%b expected %h/%0d (R11 same-cycle)",
               tag, step_val, carry_out, 16'(exp_val), exp_c);
    end
  endtask

  // one cycle: drive at falling edge, compare one unit later
  task automatic cycle(input logic ld, input logic [15:0] v, input logic u,
                       input logic d, input logic s1, input logic s2, input string tag);
    @(negedge clk);
    load_en = ld; bus_val = v; go_up = u; go_down = d; by_one = s1; by_two = s2;
    #1;
    compare(tag == "" ? pick_tag() : tag);
  endtask

  task automatic load_then(input logic [15:0] v, input logic u, input logic d,
                           input logic s1, input logic s2);
    cycle(1'b1, v, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    cycle(1'b0, 16'hDEAD, u, d, s1, s2, "");
  endtask

  initial begin
    rst = 1'b1; load_en = 1'b1; bus_val = 16'h5A5A;
    go_up = 0; go_down = 0; by_one = 0; by_two = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    checks++;
    if (addr_out !== 16'h0) begin
      errors++;
      $display("FAIL R1 reset addr actual %h expected 0000", addr_out);
    end
    rst = 1'b0;
    cycle(1'b0, 16'h1111, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    // wrap corners
    load_then(16'hFFFF, 1, 0, 1, 0);
    load_then(16'hFFFE, 1, 0, 1, 0);
    load_then(16'hFFFE, 1, 0, 0, 1);
    load_then(16'hFFFF, 1, 0, 0, 1);
    load_then(16'hFFFD, 1, 0, 0, 1);
    load_then(16'h0000, 0, 1, 1, 0);
    load_then(16'h0001, 0, 1, 1, 0);
    load_then(16'h0001, 0, 1, 0, 1);
    load_then(16'h0000, 0, 1, 0, 1);
    load_then(16'h0002, 0, 1, 0, 1);
    load_then(16'h1234, 1, 1, 1, 0);
    load_then(16'hFFFF, 0, 0, 0, 1);
    load_then(16'hFFFF, 1, 0, 0, 0);
    load_then(16'h0000, 0, 1, 0, 0);
    load_then(16'hFFFE, 1, 0, 1, 1);
    load_then(16'h0001, 0, 1, 1, 1);
    // hold: loaded value survives idle cycles with the stepper active
    cycle(1'b1, 16'hBEEF, 1, 0, 1, 0, "R2");
    for (int i = 0; i < 4; i++) cycle(1'b0, 16'h0F0F, 0, 1, 0, 1, "R3");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] v;
      v = 16'($urandom);
      if ($urandom_range(0, 3) == 0) v = 16'($urandom_range(0, 2)) - 16'd1;
      cycle(1'($urandom_range(0, 1)), v, 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), "");
    end
    // reset in mid-run
    @(negedge clk); rst = 1'b1; load_en = 1'b1; bus_val = 16'h7777;
    @(negedge clk); rst = 1'b0; load_en = 1'b0; #1;
    checks++;
    if (addr_out !== 16'h0) begin
      errors++;
      $display("FAIL R1 mid-run reset addr actual %h expected 0000", addr_out);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule